// File: doc/BRIEF.md
# Constant Reciprocal Scaling Divider

This block divides a stream of 24-bit unsigned integer samples by the fixed non-integer constant 1.36 without any divider circuit. The reciprocal 1/1.36 is held as a 24-bit unsigned fraction. Its value is 2^24/1.36 rounded to the nearest integer, which is 12336188, and all 24 of its bits lie below the binary point. The block multiplies each sample by this fraction. Because the coefficient is fixed, the multiply reduces to a sum of left-shifted copies of the sample, one copy for each set coefficient bit.

The shifted copies are split into four slices, each covering six coefficient bits. Each slice is summed and registered. The slice sums are then added in pairs and registered. A last adder combines the pair sums, and the output register keeps the upper 24 bits of the 48-bit product. That product has 24 integer bits and 24 fraction bits, and dropping the fraction bits truncates the quotient toward zero. A valid strobe runs alongside the data through a three-stage delay line. A new sample can be accepted on every clock.

Top module: `recip_scale_div`

## Requirements
- R1: For every input x accepted with `in_valid_i` high, the output `q_o` equals floor(x * 12336188 / 2^24).
- R2: A sample accepted at clock edge k appears on `q_o` after clock edge k+3, so the latency is exactly three cycles.
- R3: `out_valid_o` is high after edge k+3 exactly when `in_valid_i` was high at edge k. It stays low for every cycle in which no sample was accepted three cycles earlier.
- R4: While `rst_ni` is low, `q_o` is 0 and `out_valid_o` is 0, and this does not wait for a clock edge.
- R5: Each valid quotient equals floor(x / 1.36) or is one less than it.
- R6: The quotient never overflows. The largest input, 16777215, gives 12336187, and no valid output exceeds 12336187.
- R7: Samples presented on consecutive cycles give independent results, one per cycle, and no sample affects a neighbouring result.
- R8: An input of 0 gives 0 and an input of 1 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Marks `in_data_i` as a sample to divide |
| in_data_i | input | 24 | Unsigned integer dividend |
| out_valid_o | output | 1 | Marks `q_o` as a quotient |
| q_o | output | 24 | Truncated quotient, in_data_i / 1.36 |

## Verification
The hardest case to reach is a carry that starts in the low slices and has to ripple through the fraction bits into the integer part. This happens only for inputs whose product lies just below an integer boundary. A correct result there depends on every slice and both adder levels working together. The stimulus reaches these cases with contiguous sweeps at the bottom and top of the input range and a strided sweep that covers the whole range, all streamed back to back with gaps in the valid strobe. Random samples and a reset applied in the middle of the stream complete the coverage.

// File: rtl/recip_scale_pkg.sv
package recip_scale_pkg;
  // divisor expressed as DIVR_NUM / DIVR_DEN (1.36 = 136/100)
  localparam int unsigned DIVR_NUM = 136;
  localparam int unsigned DIVR_DEN = 100;
  localparam int unsigned DATA_W   = 24;
  localparam int unsigned FRAC_W   = 24;

  // reciprocal as an unsigned FRAC_W-bit fraction, rounded to nearest
  function automatic longint unsigned recip_coef(int unsigned frac_w);
    longint unsigned num;
    num = (longint'(DIVR_DEN) << frac_w) + longint'(DIVR_NUM / 2);
    return num / longint'(DIVR_NUM);
  endfunction
endpackage

// File: rtl/rsd_slice_sum.sv
module rsd_slice_sum #(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned PROD_W  = 48,
  parameter int unsigned COEF_W  = 24,
  parameter int unsigned BASE    = 0,
  parameter int unsigned SLICE_W = 6,
  parameter logic [COEF_W-1:0] COEF = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] x_i,
  output logic [PROD_W-1:0] sum_o
);
  logic [PROD_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < int'(SLICE_W); i++) begin
      if (COEF[BASE+i]) acc = acc + (PROD_W'(x_i) << (BASE + i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else         sum_o <= acc;
  end
endmodule

// File: rtl/rsd_pair_add.sv
module rsd_pair_add #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else         sum_o <= a_i + b_i;
  end
endmodule

// File: rtl/rsd_valid_pipe.sv
module rsd_valid_pipe #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic v_i,
  output logic v_o
);
  logic [DEPTH-1:0] sr;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr <= '0;
        else         sr <= v_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr <= '0;
        else         sr <= {sr[DEPTH-2:0], v_i};
      end
    end
  endgenerate

  assign v_o = sr[DEPTH-1];
endmodule

// File: rtl/recip_scale_div.sv
module recip_scale_div
  import recip_scale_pkg::*;
#(
  parameter int unsigned IN_W    = DATA_W,
  parameter int unsigned CF_W    = FRAC_W,
  parameter int unsigned SLICES  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [IN_W-1:0] in_data_i,
  output logic            out_valid_o,
  output logic [IN_W-1:0] q_o
);
  localparam int unsigned PROD_W  = IN_W + CF_W;
  localparam int unsigned SLICE_W = CF_W / SLICES;
  localparam int unsigned PAIRS   = SLICES / 2;
  localparam int unsigned LAT     = 3;
  localparam logic [CF_W-1:0] COEF = CF_W'(recip_coef(CF_W));

  logic [PROD_W-1:0] slice_sum [SLICES];
  logic [PROD_W-1:0] pair_sum  [PAIRS];
  logic [PROD_W-1:0] prod;

  // stage 1: one registered partial sum per coefficient slice
  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    rsd_slice_sum #(
      .DATA_W (IN_W),
      .PROD_W (PROD_W),
      .COEF_W (CF_W),
      .BASE   (s * SLICE_W),
      .SLICE_W(SLICE_W),
      .COEF   (COEF)
    ) slice_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .x_i   (in_data_i),
      .sum_o (slice_sum[s])
    );
  end

  // stage 2: pairwise adds
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    rsd_pair_add #(.W(PROD_W)) pair_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_i   (slice_sum[2*p]),
      .b_i   (slice_sum[2*p+1]),
      .sum_o (pair_sum[p])
    );
  end

  // stage 3: final add, keep integer part (truncation)
  always_comb begin
    prod = '0;
    for (int p = 0; p < int'(PAIRS); p++) prod = prod + pair_sum[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= IN_W'(prod >> CF_W);
  end

  rsd_valid_pipe #(.DEPTH(LAT)) vpipe_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .v_i   (in_valid_i),
    .v_o   (out_valid_o)
  );
endmodule

// File: rtl/recip_scale_div_chk.sv
module recip_scale_div_chk
  import recip_scale_pkg::*;
#(
  parameter int unsigned IN_W = DATA_W,
  parameter int unsigned CF_W = FRAC_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic [IN_W-1:0] in_data_i,
  input logic            out_valid_o,
  input logic [IN_W-1:0] q_o
);
  localparam longint unsigned COEF  = recip_coef(CF_W);
  localparam longint unsigned MAX_X = (64'd1 << IN_W) - 64'd1;
  localparam longint unsigned MAX_Q = (MAX_X * COEF) >> CF_W;

  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  wire hist_ok = (since_rst == 2'd3);

  function automatic longint unsigned ref_q(logic [IN_W-1:0] x);
    return (longint'(x) * COEF) >> CF_W;
  endfunction

  function automatic longint unsigned true_q(logic [IN_W-1:0] x);
    return (longint'(x) * longint'(DIVR_DEN)) / longint'(DIVR_NUM);
  endfunction

  // R3
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_ok |-> (out_valid_o == $past(in_valid_i, 3)));

  // R1
  quotient_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_ok && out_valid_o) |-> (longint'(q_o) == ref_q($past(in_data_i, 3))));

  // R5
  within_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_ok && out_valid_o) |->
      ((longint'(q_o) <= true_q($past(in_data_i, 3))) &&
       (longint'(q_o) + 64'd1 >= true_q($past(in_data_i, 3)))));

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (longint'(q_o) <= MAX_Q));

  // R4
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0 && !out_valid_o));
endmodule

bind recip_scale_div recip_scale_div_chk #(.IN_W(IN_W), .CF_W(CF_W)) chk_i (.*);

// File: tb/recip_scale_div_tb_top.sv
module recip_scale_div_tb_top;
  localparam longint unsigned COEF = 64'd12336188;
  localparam int unsigned     W    = 24;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [W-1:0] in_data_i = '0;
  logic         out_valid_o;
  logic [W-1:0] q_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic         h_v [3];
  logic [W-1:0] h_d [3];

  always #5 clk_i = ~clk_i;

  recip_scale_div dut_i (.*);

  task automatic fail_msg(string req, longint unsigned act, longint unsigned exp);
    n_fail++;
    $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 3; i++) begin h_v[i] = 1'b0; h_d[i] = '0; end
  endtask

  // one cycle: check output for the sample driven three negedges ago, then drive
  task automatic step(input bit v, input logic [W-1:0] d);
    longint unsigned exp_q, flo;
    @(negedge clk_i);
    n_vec++;
    if (out_valid_o !== h_v[2]) fail_msg("R3 valid", 64'(out_valid_o), 64'(h_v[2]));
    if (h_v[2]) begin
      exp_q = (longint'(h_d[2]) * COEF) >> 24;
      flo   = (longint'(h_d[2]) * 64'd100) / 64'd136;
      n_vec++;
      // R1 R2 R7: exact truncated product with 3-cycle latency, back to back
      if (longint'(q_o) != exp_q) fail_msg("R1/R2/R7 quotient", 64'(q_o), exp_q);
      n_vec++;
      // R5
      if (longint'(q_o) > flo || longint'(q_o) + 1 < flo) fail_msg("R5 lsb bound", 64'(q_o), flo);
      if (h_d[2] == '1) begin
        n_vec++;
        // R6
        if (q_o != 24'd12336187) fail_msg("R6 max input", 64'(q_o), 64'd12336187);
      end
      if (h_d[2] < 2) begin
        n_vec++;
        // R8
        if (q_o != '0) fail_msg("R8 small input", 64'(q_o), 0);
      end
    end
    h_v[2] = h_v[1]; h_d[2] = h_d[1];
    h_v[1] = h_v[0]; h_d[1] = h_d[0];
    h_v[0] = v;      h_d[0] = d;
    in_valid_i = v;
    in_data_i  = d;
  endtask

  task automatic reset_check(string tag);
    n_vec++;
    // R4
    if (q_o !== '0 || out_valid_o !== 1'b0)
      fail_msg({"R4 reset ", tag}, {39'd0, out_valid_o, q_o}, 0);
  endtask

  initial begin
    clear_hist();
    #3;
    reset_check("initial");
    repeat (3) @(negedge clk_i);
    reset_check("held");
    rst_ni = 1'b1;

    // R8 and contiguous low range, streamed every cycle (R7)
    for (int i = 0; i < 4096; i++) step(1'b1, W'(i));
    // top of range including max (R6)
    for (int i = 0; i < 4096; i++) step(1'b1, W'(32'hFFFFFF - i));
    // strided sweep across whole range with valid gaps (R3)
    for (int i = 0; i < 4096; i++) step((i % 5) != 3, W'(i * 4099 + (i % 7)));

    // mid-stream async reset (R4)
    step(1'b1, 24'hABCDEF);
    step(1'b1, 24'h123456);
    #2 rst_ni = 1'b0;
    #1 reset_check("mid-stream");
    clear_hist();
    in_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    reset_check("mid-stream held");
    rst_ni = 1'b1;

    // random samples with random gaps
    for (int i = 0; i < 4000; i++) step(($urandom % 4) != 0, W'($urandom));
    for (int i = 0; i < 4; i++) step(1'b0, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule